// File: doc/BRIEF.md
# Banked Scratchpad RAM with Upward Stack

This block is the 128-byte on-chip data store of a small 8-bit controller core. One store serves four kinds of access. Register-number access reaches one of four eight-byte banks, picked by two bank bits from the status word. Byte access reaches any location, either at a given address or through a pointer held in the first or second register of the active bank. Bit access reaches the 128 single bits of a sixteen-byte window. Push and pop run a stack that grows toward higher addresses.

The core issues at most one command per cycle in normal use. When several are raised together, a fixed priority picks one and the rest are dropped. Read results appear on a registered byte output, or a registered bit output, one cycle after the request. The stack pointer is visible at all times. The asynchronous reset is released to the logic through a two-stage synchronizer.

Top module: `iram_core`

## Requirements
- R1: A byte request with `byte_ind`=0 writes `byte_wdata` to address `byte_addr`, or reads it. Read data appears on `rd_data` after the next clock edge, and `rd_data` holds its value in every cycle with no granted byte read.
- R2: A register request for register n (0..7) reaches byte address `bank_sel`*8 + n. `bank_sel` carries status-word bits 4 and 3, bit 4 as the MSB.
- R3: A byte request with `byte_ind`=1 uses as its address the low 7 bits of the byte held in register `byte_ptr` (0 = first, 1 = second) of the active bank. Bit 7 of the pointer is ignored.
- R4: Bit address b (0..127) names bit b[2:0] of byte 32 + b[6:3]. A bit write stores `bit_val` into that bit only. A bit read returns it on `rd_bit` after the next clock edge, and `rd_bit` otherwise holds its value.
- R5: Reset sets the stack pointer to 7 and clears `rd_data` and `rd_bit`.
- R6: A push alone first raises the stack pointer by one, then stores `push_data` at the new pointer value.
- R7: A pop alone returns the byte at the current pointer on `rd_data`, then lowers the pointer by one.
- R8: The stack pointer wraps modulo 128 in both directions: a push at 127 writes address 0, and a pop at 0 leaves 127.
- R9: A push and a pop raised in the same cycle change neither the pointer nor the store.
- R10: Requests in the same cycle are served in this order: push or pop, then register, then byte, then bit. Lower-ranked requests in that cycle are dropped.
- R11: Requests are ignored until the second rising clock edge after `rst_n` rises, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Bank bits from the status word |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read (register access) |
| reg_num | input | 3 | Register number in the active bank |
| reg_wdata | input | 8 | Register write data |
| byte_req | input | 1 | Byte access request |
| byte_wr | input | 1 | 1 = write, 0 = read (byte access) |
| byte_ind | input | 1 | 1 = address taken from a pointer register |
| byte_ptr | input | 1 | Pointer register select |
| byte_addr | input | 7 | Given byte address |
| byte_wdata | input | 8 | Byte write data |
| bit_req | input | 1 | Bit access request |
| bit_wr | input | 1 | 1 = write, 0 = read (bit access) |
| bit_addr | input | 7 | Bit address |
| bit_val | input | 1 | Bit write value |
| push | input | 1 | Push command |
| pop | input | 1 | Pop command |
| push_data | input | 8 | Byte to push |
| rd_data | output | 8 | Registered byte read result |
| rd_bit | output | 1 | Registered bit read result |
| sp | output | 7 | Current stack pointer |

## Verification
Two pairs of functions can meet in one cycle. The first is a push and a pop together. The second is a stack command together with a register, byte or bit access. The bench raises push and pop in the same cycle as a byte write, and checks that the pointer has not moved while the byte write still lands. It also raises a push next to a register write, and a register write next to byte and bit writes, then reads back every location involved to confirm that only the top-ranked command reached the store.

// File: rtl/iram_pkg.sv
`timescale 1ns/1ps
package iram_pkg;
  localparam int DEPTH     = 128;
  localparam int DW        = 8;
  localparam int AW        = $clog2(DEPTH);
  localparam int BANKS     = 4;
  localparam int REGS      = 8;
  localparam int BANK_W    = $clog2(BANKS);
  localparam int REG_W     = $clog2(REGS);
  localparam int BIT_IW    = $clog2(DW);
  localparam int BIT_BASE  = 32;
  localparam int SP_RST    = 7;
  localparam int SYNC_STG  = 2;

  typedef enum logic [2:0] {
    GR_NONE, GR_PUSH, GR_POP, GR_REG, GR_BYTE, GR_BIT
  } grant_e;
endpackage

// File: rtl/iram_rst_sync.sv
`timescale 1ns/1ps
module iram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign rst_sync_n = stg_q[STAGES-1];
endmodule

// File: rtl/iram_addr_map.sv
`timescale 1ns/1ps
module iram_addr_map
  import iram_pkg::*;
(
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [REG_W-1:0]  reg_num,
  input  logic              byte_ptr,
  input  logic [AW-1:0]     bit_addr,
  output logic [AW-1:0]     reg_addr,
  output logic [AW-1:0]     ptr_addr,
  output logic [AW-1:0]     bit_byte_addr,
  output logic [BIT_IW-1:0] bit_idx
);
  localparam int LOC_W = BANK_W + REG_W;

  logic [LOC_W-1:0] reg_loc;
  logic [LOC_W-1:0] ptr_loc;

  always_comb begin
    reg_loc       = {bank_sel, reg_num};
    ptr_loc       = {bank_sel, {(REG_W-1){1'b0}}, byte_ptr};
    reg_addr      = AW'(reg_loc);
    ptr_addr      = AW'(ptr_loc);
    bit_byte_addr = AW'(BIT_BASE) + AW'(bit_addr[AW-1:BIT_IW]);
    bit_idx       = bit_addr[BIT_IW-1:0];
  end
endmodule

// File: rtl/iram_sp_unit.sv
`timescale 1ns/1ps
module iram_sp_unit
  import iram_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_go,
  input  logic          pop_go,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_inc
);
  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_d;
  logic          sp_en;

  always_comb begin
    sp_inc = sp_q + AW'(1);
    sp_en  = push_go | pop_go;
    sp_d   = sp_q;
    if (push_go)     sp_d = sp_inc;
    else if (pop_go) sp_d = sp_q - AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= AW'(SP_RST);
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;
endmodule

// File: rtl/iram_array.sv
`timescale 1ns/1ps
module iram_array
  import iram_pkg::*;
(
  input  logic          clk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] paddr,
  output logic [AW-1:0] pdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) mem[waddr] <= wdata;
  end

  always_comb begin
    rdata = mem[raddr];
    pdata = mem[paddr][AW-1:0];
  end
endmodule

// File: rtl/iram_core.sv
`timescale 1ns/1ps
module iram_core
  import iram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_num,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              byte_req,
  input  logic              byte_wr,
  input  logic              byte_ind,
  input  logic              byte_ptr,
  input  logic [AW-1:0]     byte_addr,
  input  logic [DW-1:0]     byte_wdata,
  input  logic              bit_req,
  input  logic              bit_wr,
  input  logic [AW-1:0]     bit_addr,
  input  logic              bit_val,
  input  logic              push,
  input  logic              pop,
  input  logic [DW-1:0]     push_data,
  output logic [DW-1:0]     rd_data,
  output logic              rd_bit,
  output logic [AW-1:0]     sp
);
  logic              rst_sync_n;
  logic [AW-1:0]     reg_addr, ptr_addr, bit_byte_addr, ptr_val, eff_addr;
  logic [BIT_IW-1:0] bit_idx;
  logic              push_go, pop_go;
  logic [AW-1:0]     sp_inc;
  grant_e            gnt;
  logic              wen, ld_byte, ld_bit;
  logic [AW-1:0]     waddr, raddr;
  logic [DW-1:0]     wdata, arr_rdata, bit_mod;
  logic [DW-1:0]     rd_data_q;
  logic              rd_bit_q;

  iram_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  iram_addr_map u_map (
    .bank_sel(bank_sel), .reg_num(reg_num), .byte_ptr(byte_ptr),
    .bit_addr(bit_addr), .reg_addr(reg_addr), .ptr_addr(ptr_addr),
    .bit_byte_addr(bit_byte_addr), .bit_idx(bit_idx)
  );

  always_comb begin
    push_go  = rst_sync_n & push & ~pop;
    pop_go   = rst_sync_n & pop & ~push;
    eff_addr = byte_ind ? ptr_val : byte_addr;
  end

  iram_sp_unit u_sp (
    .clk(clk), .rst_n(rst_sync_n), .push_go(push_go), .pop_go(pop_go),
    .sp(sp), .sp_inc(sp_inc)
  );

  always_comb begin
    gnt = GR_NONE;
    if (rst_sync_n) begin
      if (push_go)       gnt = GR_PUSH;
      else if (pop_go)   gnt = GR_POP;
      else if (reg_req)  gnt = GR_REG;
      else if (byte_req) gnt = GR_BYTE;
      else if (bit_req)  gnt = GR_BIT;
    end
  end

  for (genvar gi = 0; gi < DW; gi++) begin : g_bitmod
    assign bit_mod[gi] = (bit_idx == BIT_IW'(gi)) ? bit_val : arr_rdata[gi];
  end

  always_comb begin
    wen     = 1'b0;
    waddr   = sp_inc;
    wdata   = push_data;
    raddr   = sp;
    ld_byte = 1'b0;
    ld_bit  = 1'b0;
    unique case (gnt)
      GR_PUSH: begin
        wen = 1'b1;
      end
      GR_POP: begin
        ld_byte = 1'b1;
      end
      GR_REG: begin
        raddr   = reg_addr;
        waddr   = reg_addr;
        wdata   = reg_wdata;
        wen     = reg_wr;
        ld_byte = ~reg_wr;
      end
      GR_BYTE: begin
        raddr   = eff_addr;
        waddr   = eff_addr;
        wdata   = byte_wdata;
        wen     = byte_wr;
        ld_byte = ~byte_wr;
      end
      GR_BIT: begin
        raddr  = bit_byte_addr;
        waddr  = bit_byte_addr;
        wdata  = bit_mod;
        wen    = bit_wr;
        ld_bit = ~bit_wr;
      end
      default: begin
        wen = 1'b0;
      end
    endcase
  end

  iram_array u_arr (
    .clk(clk), .wen(wen), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(arr_rdata), .paddr(ptr_addr), .pdata(ptr_val)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rd_data_q <= '0;
    else if (ld_byte) rd_data_q <= arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_bit_q <= 1'b0;
    else if (ld_bit) rd_bit_q <= arr_rdata[bit_idx];
  end

  assign rd_data = rd_data_q;
  assign rd_bit  = rd_bit_q;
endmodule

// File: rtl/iram_core_chk.sv
`timescale 1ns/1ps
module iram_core_chk
  import iram_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          rst_sync_n,
  input logic          push,
  input logic          pop,
  input logic          reg_req,
  input logic          reg_wr,
  input logic          byte_req,
  input logic          byte_wr,
  input logic          bit_req,
  input logic          bit_wr,
  input logic [DW-1:0] rd_data,
  input logic          rd_bit,
  input logic [AW-1:0] sp
);
  logic no_stack, byte_rd_gnt, bit_rd_gnt;

  always_comb begin
    no_stack    = (push == pop);
    byte_rd_gnt = (pop & ~push) |
                  (no_stack & (reg_req ? ~reg_wr : (byte_req & ~byte_wr)));
    bit_rd_gnt  = no_stack & ~reg_req & ~byte_req & bit_req & ~bit_wr;
  end

  p_sp_reset_r5: assert property (@(posedge clk)
    !rst_n |=> (sp == AW'(SP_RST)));

  p_sp_push_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (push && !pop) |=> (sp == AW'($past(sp) + AW'(1))));

  p_sp_pop_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pop && !push) |=> (sp == AW'($past(sp) - AW'(1))));

  p_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (push == pop) |=> $stable(sp));

  p_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !byte_rd_gnt |=> $stable(rd_data));

  p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bit_rd_gnt |=> $stable(rd_bit));
endmodule

bind iram_core iram_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n),
  .push(push), .pop(pop), .reg_req(reg_req), .reg_wr(reg_wr),
  .byte_req(byte_req), .byte_wr(byte_wr), .bit_req(bit_req), .bit_wr(bit_wr),
  .rd_data(rd_data), .rd_bit(rd_bit), .sp(sp)
);

// File: tb/sim_iram_core.sv
`timescale 1ns/1ps
module sim_iram_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bank_sel;
  logic       reg_req, reg_wr;
  logic [2:0] reg_num;
  logic [7:0] reg_wdata;
  logic       byte_req, byte_wr, byte_ind, byte_ptr;
  logic [6:0] byte_addr;
  logic [7:0] byte_wdata;
  logic       bit_req, bit_wr, bit_val;
  logic [6:0] bit_addr;
  logic       push, pop;
  logic [7:0] push_data;
  logic [7:0] rd_data;
  logic       rd_bit;
  logic [6:0] sp;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;
  logic [7:0]  mdl [128];
  logic [6:0]  msp;

  always #2 clk = ~clk;

  iram_core u0 (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_num(reg_num), .reg_wdata(reg_wdata),
    .byte_req(byte_req), .byte_wr(byte_wr), .byte_ind(byte_ind), .byte_ptr(byte_ptr),
    .byte_addr(byte_addr), .byte_wdata(byte_wdata),
    .bit_req(bit_req), .bit_wr(bit_wr), .bit_addr(bit_addr), .bit_val(bit_val),
    .push(push), .pop(pop), .push_data(push_data),
    .rd_data(rd_data), .rd_bit(rd_bit), .sp(sp)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_req = 0; reg_wr = 0; byte_req = 0; byte_wr = 0; byte_ind = 0;
    bit_req = 0; bit_wr = 0; push = 0; pop = 0;
  endtask

  task automatic byte_write(input logic [6:0] a, input logic [7:0] d);
    byte_req = 1; byte_wr = 1; byte_ind = 0; byte_addr = a; byte_wdata = d;
    cyc(); idle();
    mdl[a] = d;
  endtask

  task automatic byte_check(input logic [6:0] a, input string req);
    byte_req = 1; byte_wr = 0; byte_ind = 0; byte_addr = a;
    cyc(); idle();
    chk(req, rd_data, mdl[a]);
  endtask

  task automatic do_push(input logic [7:0] d);
    push = 1; push_data = d;
    cyc(); idle();
    msp = msp + 7'd1;
    mdl[msp] = d;
    chk("R6 sp after push", sp, msp);
  endtask

  task automatic do_pop(input string req);
    pop = 1;
    cyc(); idle();
    chk(req, rd_data, mdl[msp]);
    msp = msp - 7'd1;
    chk("R7 sp after pop", sp, msp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bank_sel = 0; reg_num = 0; reg_wdata = 0; byte_addr = 0;
    byte_wdata = 0; bit_addr = 0; bit_val = 0; push_data = 0;
    idle();
    repeat (4) cyc();
    // R5: reset values
    chk("R5 sp reset", sp, 7);
    chk("R5 rd_data reset", rd_data, 0);
    chk("R5 rd_bit reset", rd_bit, 0);
    msp = 7'd7;

    // R11: push held through the two synchronizer edges is ignored
    rst_n = 1; push = 1; push_data = 8'hAA;
    cyc(); cyc(); idle();
    chk("R11 push ignored during release", sp, 7);

    // R1: full sweep of direct byte access
    for (int a = 0; a < 128; a++) byte_write(7'(a), 8'((a * 37 + 5) & 8'hFF));
    for (int a = 0; a < 128; a++) byte_check(7'(a), "R1 direct byte read");
    cyc();
    chk("R1 rd_data held while idle", rd_data, mdl[127]);

    // R2: register banks
    for (int bk = 0; bk < 4; bk++) begin
      for (int n = 0; n < 8; n++) begin
        bank_sel = 2'(bk); reg_req = 1; reg_wr = 1; reg_num = 3'(n);
        reg_wdata = 8'(8'h90 + bk * 16 + n);
        cyc(); idle();
        mdl[bk * 8 + n] = 8'(8'h90 + bk * 16 + n);
      end
    end
    for (int a = 0; a < 32; a++) byte_check(7'(a), "R2 bank write seen at bank*8+n");
    for (int bk = 0; bk < 4; bk++) begin
      for (int n = 0; n < 8; n++) begin
        bank_sel = 2'(3 - bk); reg_req = 1; reg_wr = 0; reg_num = 3'(n);
        cyc(); idle();
        chk("R2 register read", rd_data, mdl[(3 - bk) * 8 + n]);
      end
    end

    // R3: indirect access through first/second register of bank 2
    bank_sel = 2; reg_req = 1; reg_wr = 1; reg_num = 1; reg_wdata = 8'hC5;
    cyc(); idle(); mdl[17] = 8'hC5;
    reg_req = 1; reg_wr = 1; reg_num = 0; reg_wdata = 8'h50;
    cyc(); idle(); mdl[16] = 8'h50;
    byte_req = 1; byte_wr = 1; byte_ind = 1; byte_ptr = 1; byte_wdata = 8'h3C;
    byte_addr = 7'h10;
    cyc(); idle(); mdl[7'h45] = 8'h3C;
    byte_check(7'h45, "R3 indirect write uses low 7 pointer bits");
    byte_check(7'h10, "R3 given address untouched by indirect write");
    byte_req = 1; byte_wr = 0; byte_ind = 1; byte_ptr = 0;
    cyc(); idle();
    chk("R3 indirect read via first register", rd_data, mdl[7'h50]);

    // R4: bit sweep
    for (int b = 0; b < 128; b++) begin
      logic v;
      v = 1'(((b * 7) >> 2) & 1);
      bit_req = 1; bit_wr = 1; bit_addr = 7'(b); bit_val = v;
      cyc(); idle();
      mdl[32 + b / 8][b % 8] = v;
      bit_req = 1; bit_wr = 0;
      cyc(); idle();
      chk("R4 bit read", rd_bit, v);
    end
    for (int a = 0; a < 128; a++) byte_check(7'(a), "R4 only addressed bit changed");

    // R6/R7: push then pop in reverse order
    do_push(8'h11); do_push(8'h22); do_push(8'h33);
    byte_check(7'd8, "R6 first push stored at 8");
    byte_check(7'd10, "R6 third push stored at 10");
    do_pop("R7 pop returns last push");
    do_pop("R7 pop returns middle push");
    do_pop("R7 pop returns first push");

    // R9 with R10: push+pop with byte write; stack ignored, byte served
    push = 1; pop = 1; push_data = 8'hEE;
    byte_req = 1; byte_wr = 1; byte_ind = 0; byte_addr = 7'h70; byte_wdata = 8'h5A;
    cyc(); idle(); mdl[7'h70] = 8'h5A;
    chk("R9 sp unchanged on push+pop", sp, msp);
    byte_check(7'h70, "R10 byte write served beside push+pop");
    byte_check(7'd8, "R9 no store on push+pop");

    // R10: push beats register write
    bank_sel = 0; push = 1; push_data = 8'h77;
    reg_req = 1; reg_wr = 1; reg_num = 5; reg_wdata = 8'h01;
    cyc(); idle(); msp = msp + 7'd1; mdl[msp] = 8'h77;
    byte_check(7'd5, "R10 register write dropped under push");
    byte_check(msp, "R10 push stored");
    // R10: register write beats byte and bit writes
    reg_req = 1; reg_wr = 1; reg_num = 2; reg_wdata = 8'h11;
    byte_req = 1; byte_wr = 1; byte_addr = 7'h60; byte_wdata = 8'h22;
    bit_req = 1; bit_wr = 1; bit_addr = 7'h00; bit_val = ~mdl[32][0];
    cyc(); idle(); mdl[2] = 8'h11;
    byte_check(7'd2, "R10 register write served");
    byte_check(7'h60, "R10 byte write dropped");
    byte_check(7'd32, "R10 bit write dropped");
    // R10: byte read beats bit read; rd_bit holds
    byte_req = 1; byte_wr = 0; byte_addr = 7'h61; bit_req = 1; bit_wr = 0;
    bit_addr = 7'h7F;
    begin
      logic hold;
      hold = rd_bit;
      cyc(); idle();
      chk("R10 byte read served over bit read", rd_data, mdl[7'h61]);
      chk("R10 rd_bit unchanged", rd_bit, hold);
    end

    // R8: wrap upward and downward
    do_pop("R7 pop before wrap");
    while (msp != 7'd127) do_push(8'(msp * 3 + 1));
    do_push(8'hB4);
    chk("R8 sp wraps to 0", sp, 0);
    byte_check(7'd0, "R8 push at 127 stores at 0");
    do_pop("R8 pop at 0 returns byte 0");
    chk("R8 sp wraps to 127", sp, 127);
    do_pop("R8 pop at 127");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule